// File: doc/BRIEF.md
# Serial PHY Management Master

This block performs register reads and writes to Ethernet PHYs over the two-wire management bus. A user puts a PHY address, a register address, a read/write flag and a 16-bit write value on a parallel request port and pulses a start strobe. The block then runs one complete management frame on its own: preamble, start field, opcode, the two addresses, turnaround and data. At the end it raises `done` for one cycle and, for a read, presents the 16 bits the PHY returned.

The management clock is made from the system clock by a divider. The half-period is set per access in system-clock cycles. A setting of zero selects a conservative default that keeps the management clock period at or above 400 ns with a 250 MHz system clock. The data line is open-drain: the block only ever requests a low level and otherwise leaves the line to the pull-up. For a read it lets go of the line over the turnaround and data phases so the PHY can answer. The line value coming back is passed through a two-flop synchronizer before it is sampled.

The frame runs 64 management-clock periods. Bit k is set up while the clock is low in period k and is taken on the following rising edge.

Top module: `mdio_master`

## Requirements
- R1: After reset, `busy`, `done`, `mdc`, `mdio_pull_low` and `rd_data` are all 0.
- R2: A `req_start` sampled while `busy` is 0 starts an access, and `busy` reads 1 from the next cycle. The request fields and divider setting are captured at that edge. A `req_start` sampled while `busy` is 1, including on the edge that ends an access, is ignored: the running frame and its timing continue unchanged.
- R3: With H the effective half-period, `mdc` counts n cycles after the accepting edge and is 1 exactly when floor(n/H) is odd, for n < 128·H. It is 0 whenever the block is idle. A change of `div_half` during an access has no effect on that access.
- R4: H is DEFAULT_HALF (50) when `div_half` is 0, and MIN_HALF (3) when `div_half` is 1 or 2. Otherwise H equals `div_half`.
- R5: Frame bit k (k = 0..63) is placed on the line during management-clock period k. Bits 0–31 are 1. Bits 32–33 are 0,1. Bits 34–35 are 1,0 for a read and 0,1 for a write. Bits 36–40 carry the PHY address MSB first, and bits 41–45 carry the register address MSB first. For a write, bits 46–47 are 1,0 and bits 48–63 carry the write data MSB first.
- R6: `mdio_pull_low` is 1 only while a 0 bit is being sent. A 1 bit and the idle state leave the line released.
- R7: During a read, `mdio_pull_low` is 0 for the whole of periods 46 to 63.
- R8: During a read, the block takes the synchronized line value at the rising `mdc` edge of each of periods 48–63, MSB first. `rd_data` takes the 16 collected bits on the edge that ends the access and changes at no other time. A write leaves `rd_data` unchanged.
- R9: The access ends 128·H cycles after the accepting edge. On that edge `busy` returns to 0 and `done` is 1 for exactly one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_start | input | 1 | Start strobe for one access |
| req_read | input | 1 | 1 = read, 0 = write |
| req_phy | input | 5 | Target PHY address |
| req_reg | input | 5 | Target register address |
| req_wdata | input | 16 | Data for a write |
| div_half | input | DIV_W (8) | Management clock half-period in system cycles; 0 selects the default |
| busy | output | 1 | Access in progress |
| done | output | 1 | One-cycle pulse at the end of an access |
| rd_data | output | 16 | Data returned by the last read |
| mdc | output | 1 | Management clock toward the PHY |
| mdio_pull_low | output | 1 | Open-drain enable: 1 pulls the data line low |
| mdio_in | input | 1 | Data line level as seen at the pin |

## Verification
The hardest cases to reach are the edges where a new strobe coincides with protocol events. These are a strobe held across the very edge that completes an access, which must be ignored, and then accepted on the next edge, and a strobe with different fields and a different divider arriving mid-frame. The bench builds both by placing the strobe against its own model's cycle count: once at period 40 of a read, and once held from the last cycle of an access. A modelled PHY answers reads by driving its bit from the start of each data period, so the synchronizer latency and the rising-edge sample point are exercised at the minimum half-period of 3 cycles.

// File: rtl/mdio_pkg.sv
package mdio_pkg;
  localparam int FRAME_LEN  = 64;
  localparam int PRE_LEN    = 32;
  localparam int TURN_FIRST = 46;
  localparam int DATA_FIRST = 48;

  // 32-bit control+data word following the preamble, MSB sent first.
  function automatic logic [31:0] frame_word(input logic rd, input logic [4:0] phy,
                                             input logic [4:0] regad, input logic [15:0] wd);
    logic [1:0] op;
    logic [1:0] ta;
    op = rd ? 2'b10 : 2'b01;
    ta = rd ? 2'b11 : 2'b10;
    return {2'b01, op, phy, regad, ta, rd ? 16'hFFFF : wd};
  endfunction

  // Level of frame bit idx: preamble ones, then the word MSB first.
  function automatic logic frame_bit(input logic [31:0] w, input logic [5:0] idx);
    logic [5:0] j;
    j = 6'd63 - idx;
    if (idx < 6'd32) return 1'b1;
    return w[j[4:0]];
  endfunction

  // Reads hand the line to the PHY from the turnaround on.
  function automatic logic line_released(input logic rd, input logic [5:0] idx);
    return rd && (idx >= 6'd46);
  endfunction
endpackage

// File: rtl/mdio_sync.sv
module mdio_sync (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_i,
  output logic pin_s
);
  logic meta_q, stab_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= 1'b1;
      stab_q <= 1'b1;
    end else begin
      meta_q <= pin_i;
      stab_q <= meta_q;
    end
  end

  assign pin_s = stab_q;
endmodule

// File: rtl/mdio_clkgen.sv
module mdio_clkgen #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             restart,
  input  logic [DIV_W-1:0] half,
  output logic             mdc,
  output logic             rise_evt,
  output logic             fall_evt
);
  logic [DIV_W-1:0] cnt_q;
  logic             mdc_q;
  logic             wrap;

  assign wrap     = en && !restart && (cnt_q == half - 1'b1);
  assign rise_evt = wrap && !mdc_q;
  assign fall_evt = wrap && mdc_q;
  assign mdc      = mdc_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      mdc_q <= 1'b0;
    end else if (!en || restart) begin
      cnt_q <= '0;
      mdc_q <= 1'b0;
    end else if (wrap) begin
      cnt_q <= '0;
      mdc_q <= ~mdc_q;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  // R3: clock parked low when not enabled
  a_r3_idle_low: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> !mdc_q);
  // R3: a rising event produces a high clock
  a_r3_rise_high: assert property (@(posedge clk) disable iff (!rst_n)
    rise_evt |=> mdc_q);
  // R3: the clock never toggles between events
  a_r3_hold_between: assert property (@(posedge clk) disable iff (!rst_n)
    en && !restart && !wrap |=> $stable(mdc_q));
endmodule

// File: rtl/mdio_seq.sv
module mdio_seq
  import mdio_pkg::*;
#(
  parameter int DIV_W        = 8,
  parameter int DEFAULT_HALF = 50,
  parameter int MIN_HALF     = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_start,
  input  logic             req_read,
  input  logic [4:0]       req_phy,
  input  logic [4:0]       req_reg,
  input  logic [15:0]      req_wdata,
  input  logic [DIV_W-1:0] div_half,
  input  logic             rise_evt,
  input  logic             fall_evt,
  input  logic             line_s,
  output logic             busy,
  output logic             accept,
  output logic             done,
  output logic [DIV_W-1:0] half_q,
  output logic             pull_low,
  output logic [15:0]      rd_data
);
  localparam logic [DIV_W-1:0] DEF_H = DIV_W'(DEFAULT_HALF);
  localparam logic [DIV_W-1:0] MIN_H = DIV_W'(MIN_HALF);

  function automatic logic [DIV_W-1:0] eff_half(input logic [DIV_W-1:0] req);
    if (req == '0) return DEF_H;
    if (req < MIN_H) return MIN_H;
    return req;
  endfunction

  logic        busy_q, done_q, pull_q, rd_q;
  logic [5:0]  idx_q, idx_nx;
  logic [31:0] word_q, word_nx;
  logic [15:0] shift_q, rdata_q;
  logic        last_fall, take_bit;

  assign accept    = req_start && !busy_q;
  assign word_nx   = frame_word(req_read, req_phy, req_reg, req_wdata);
  assign idx_nx    = idx_q + 6'd1;
  assign last_fall = busy_q && fall_evt && (idx_q == 6'd63);
  assign take_bit  = busy_q && rise_evt && rd_q && (idx_q >= 6'd48);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q  <= 1'b0;
      done_q  <= 1'b0;
      pull_q  <= 1'b0;
      rd_q    <= 1'b0;
      idx_q   <= '0;
      word_q  <= '0;
      half_q  <= DEF_H;
      shift_q <= '0;
      rdata_q <= '0;
    end else begin
      done_q <= 1'b0;
      if (accept) begin
        busy_q <= 1'b1;
        idx_q  <= '0;
        word_q <= word_nx;
        rd_q   <= req_read;
        half_q <= eff_half(div_half);
        pull_q <= ~frame_bit(word_nx, 6'd0) & ~line_released(req_read, 6'd0);
      end else if (last_fall) begin
        busy_q <= 1'b0;
        done_q <= 1'b1;
        pull_q <= 1'b0;
        if (rd_q) rdata_q <= shift_q;
      end else if (busy_q && fall_evt) begin
        idx_q  <= idx_nx;
        pull_q <= ~frame_bit(word_q, idx_nx) & ~line_released(rd_q, idx_nx);
      end
      if (take_bit) shift_q <= {shift_q[14:0], line_s};
    end
  end

  assign busy     = busy_q;
  assign done     = done_q;
  assign pull_low = pull_q;
  assign rd_data  = rdata_q;

  // R2: a strobe during an access leaves the frame untouched
  a_r2_ignore_busy: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q && req_start && !last_fall |=> busy_q && $stable(word_q) && $stable(rd_q) && $stable(half_q));
  // R7: read releases the line from the turnaround on
  a_r7_release_read: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q && rd_q && (idx_q >= 6'd46) |-> !pull_q);
  // R6: never pull the line while idle
  a_r6_idle_released: assert property (@(posedge clk) disable iff (!rst_n)
    pull_q |-> busy_q);
  // R5: the line only changes at a falling management clock event
  a_r5_change_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
    $past(busy_q) && busy_q && !$past(fall_evt) |-> $stable(pull_q));
  // R9: done lasts a single cycle
  a_r9_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> !done_q);
  // R9: end of busy coincides with done
  a_r9_busy_done: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_q) |-> done_q);
  // R8: read data changes only together with done
  a_r8_rdata_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !done_q |-> $stable(rdata_q));
endmodule

// File: rtl/mdio_master.sv
module mdio_master #(
  parameter int DIV_W        = 8,
  parameter int DEFAULT_HALF = 50,
  parameter int MIN_HALF     = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_start,
  input  logic             req_read,
  input  logic [4:0]       req_phy,
  input  logic [4:0]       req_reg,
  input  logic [15:0]      req_wdata,
  input  logic [DIV_W-1:0] div_half,
  output logic             busy,
  output logic             done,
  output logic [15:0]      rd_data,
  output logic             mdc,
  output logic             mdio_pull_low,
  input  logic             mdio_in
);
  logic             line_s;
  logic             rise_evt, fall_evt;
  logic             accept;
  logic [DIV_W-1:0] half_q;

  mdio_sync u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .pin_i (mdio_in),
    .pin_s (line_s)
  );

  mdio_clkgen #(.DIV_W(DIV_W)) u_clk (
    .clk      (clk),
    .rst_n    (rst_n),
    .en       (busy),
    .restart  (accept),
    .half     (half_q),
    .mdc      (mdc),
    .rise_evt (rise_evt),
    .fall_evt (fall_evt)
  );

  mdio_seq #(
    .DIV_W        (DIV_W),
    .DEFAULT_HALF (DEFAULT_HALF),
    .MIN_HALF     (MIN_HALF)
  ) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_start (req_start),
    .req_read  (req_read),
    .req_phy   (req_phy),
    .req_reg   (req_reg),
    .req_wdata (req_wdata),
    .div_half  (div_half),
    .rise_evt  (rise_evt),
    .fall_evt  (fall_evt),
    .line_s    (line_s),
    .busy      (busy),
    .accept    (accept),
    .done      (done),
    .half_q    (half_q),
    .pull_low  (mdio_pull_low),
    .rd_data   (rd_data)
  );

  // R3: the management clock runs only during an access
  a_r3_mdc_needs_busy: assert property (@(posedge clk) disable iff (!rst_n)
    mdc |-> busy);
endmodule

// File: tb/mdio_master_test.sv
module mdio_master_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_start = 1'b0;
  logic        req_read = 1'b0;
  logic [4:0]  req_phy = '0;
  logic [4:0]  req_reg = '0;
  logic [15:0] req_wdata = '0;
  logic [7:0]  div_half = '0;
  logic        busy, done, mdc, mdio_pull_low;
  logic [15:0] rd_data;
  logic        phy_drv = 1'b1;
  logic        mdio_in;

  assign mdio_in = mdio_pull_low ? 1'b0 : phy_drv;

  mdio_master uut (
    .clk(clk), .rst_n(rst_n), .req_start(req_start), .req_read(req_read),
    .req_phy(req_phy), .req_reg(req_reg), .req_wdata(req_wdata), .div_half(div_half),
    .busy(busy), .done(done), .rd_data(rd_data), .mdc(mdc),
    .mdio_pull_low(mdio_pull_low), .mdio_in(mdio_in)
  );

  always #2 clk = ~clk;

  int checks = 0, failures = 0, cycles = 0;
  // reference model state
  bit        m_act = 0, m_done = 0, m_rd = 0;
  int        m_n = 0, m_h = 50;
  bit [4:0]  m_phy, m_reg;
  bit [15:0] m_wd, m_rdx = 0;
  bit [15:0] phy_word = 16'h0000;
  string     clk_tag = "R3";

  function automatic int half_of(int d);
    if (d == 0) return 50;
    if (d < 3) return 3;
    return d;
  endfunction

  function automatic bit ref_bit(int k);
    if (k < 32) return 1;
    case (k)
      32: return 0;
      33: return 1;
      34: return m_rd ? 1 : 0;
      35: return m_rd ? 0 : 1;
      46: return 1;
      47: return 0;
      default: ;
    endcase
    if (k <= 40) return m_phy[40 - k];
    if (k <= 45) return m_reg[45 - k];
    return m_wd[63 - k];
  endfunction

  task automatic check(string tag, int act, int exp, string what);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h cycle=%0d", tag, what, act, exp, cycles);
    end
  endtask

  task automatic finish_run();
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  task automatic step();
    bit st = req_start;
    bit rdi = req_read;
    bit [4:0] ph = req_phy, rg = req_reg;
    bit [15:0] wd = req_wdata;
    int dv = div_half;
    int k;
    bit exp_pull, rel;
    @(posedge clk);
    #1;
    cycles++;
    if (cycles > 150000) begin
      failures++;
      $display("FAIL watchdog expired");
      finish_run();
    end
    m_done = 0;
    if (m_act) begin
      m_n++;
      if (m_n == 128 * m_h) begin
        m_act = 0;
        m_done = 1;
        if (m_rd) m_rdx = phy_word;
      end
    end else if (st) begin
      m_act = 1; m_n = 0; m_rd = rdi; m_phy = ph; m_reg = rg; m_wd = wd;
      m_h = half_of(dv);
    end
    k = m_n / (2 * m_h);
    rel = m_act && m_rd && (k >= 46);
    exp_pull = m_act && !rel && (ref_bit(k) == 0);
    check("R2", busy, m_act, "busy");
    check(clk_tag, mdc, m_act && ((m_n / m_h) % 2 == 1), "mdc");
    if (rel) check("R7", mdio_pull_low, 0, "pull_low");
    else if (exp_pull) check("R5", mdio_pull_low, 1, "pull_low");
    else check("R6", mdio_pull_low, 0, "pull_low");
    check("R9", done, m_done, "done");
    check("R8", rd_data, m_rdx, "rd_data");
    // modelled PHY: answers reads from the second turnaround bit onward
    if (m_act && m_rd && k == 47) phy_drv = 1'b0;
    else if (m_act && m_rd && k >= 48) phy_drv = phy_word[63 - k];
    else phy_drv = 1'b1;
  endtask

  task automatic launch(bit rd, bit [4:0] ph, bit [4:0] rg, bit [15:0] wd, bit [7:0] dv);
    req_read = rd; req_phy = ph; req_reg = rg; req_wdata = wd; div_half = dv;
    req_start = 1'b1;
    step();
    req_start = 1'b0;
  endtask

  task automatic run_out();
    while (m_act) step();
    step();
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1;
    // R1: reset state
    check("R1", busy, 0, "busy");
    check("R1", done, 0, "done");
    check("R1", mdc, 0, "mdc");
    check("R1", mdio_pull_low, 0, "pull_low");
    check("R1", rd_data, 0, "rd_data");
    rst_n = 1'b1;
    step(); step();

    // R5 R6 write frame, R4 clamp of divider setting 1 to 3
    clk_tag = "R4";
    launch(0, 5'h11, 5'h0A, 16'hA5C3, 8'd1);
    clk_tag = "R3";
    run_out();

    // R8 read at minimum half-period with an asymmetric pattern
    phy_word = 16'hB2E1;
    launch(1, 5'h03, 5'h1F, 16'h0000, 8'd3);
    run_out();

    // R2 R3: strobe with other fields and divider arrives in period 40
    phy_word = 16'h4C7A;
    launch(1, 5'h1E, 5'h01, 16'h0000, 8'd5);
    while (m_n < 40 * 2 * m_h) step();
    req_read = 0; req_phy = 5'h00; req_reg = 5'h15; req_wdata = 16'hFFFF; div_half = 8'd3;
    req_start = 1'b1;
    step(); step();
    req_start = 1'b0;
    run_out();

    // R9 R2: strobe held across the completion edge, accepted one edge later
    launch(0, 5'h0F, 5'h10, 16'h0001, 8'd4);
    while (m_n < 128 * m_h - 1) step();
    req_read = 1; req_phy = 5'h15; req_reg = 5'h0A; div_half = 8'd4;
    phy_word = 16'h8001;
    req_start = 1'b1;
    step();            // completion edge: strobe ignored
    step();            // next edge: accepted
    req_start = 1'b0;
    check("R2", busy, 1, "busy after held strobe");
    run_out();

    // R4: default divider, R8 write leaves rd_data unchanged
    clk_tag = "R4";
    launch(0, 5'h1B, 5'h06, 16'h7E18, 8'd0);
    run_out();
    clk_tag = "R3";
    check("R8", rd_data, 16'h8001, "rd_data kept after write");

    finish_run();
  end
endmodule